// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

This block is a single channel of a general-purpose PWM timer. A counter advances on ticks from a prescaler and runs in one of three shapes: an up-counting sawtooth, a down-counting sawtooth, or a symmetric up/down triangle. A period register sets the top of the count. Two compare registers each drive their own output, so two independent duty cycles come out of one shared counter.

Each compare register sits behind a buffer register. With buffering on, the buffer value moves into the active compare register only at a selected turning point of the count: the crest (count equal to period) or the trough (count equal to zero). In triangle mode this lets software give the rising and falling halves of a pulse different edges, which yields laterally asymmetric PWM. The transfer also happens once when the counter starts. The counter raises one-cycle overflow and underflow pulses. Each pulse can be routed to an interrupt line.

Software drives the channel through a small word-addressed register port. The mode and prescaler fields are locked while the channel runs. Clearing the run bit stops the counter and pulls both outputs low.

Top module: `pwm_tc_chan`

## Requirements
- R1: After reset, both PWM outputs, both event pulses and the interrupt are low, and every register reads as zero.
- R2: In mode code 0 (up sawtooth), the count goes 0,1,…,P and then wraps to 0, so a frame is P+1 ticks. An output is high whenever count < its compare value, giving compare×divider high cycles per frame when compare ≤ P+1.
- R3: In mode code 1 (down sawtooth), the count starts at P, goes down to 0 and then reloads P. The same count < compare rule sets the output level.
- R4: In mode codes 2 and 3 (triangle), the count climbs from 0 to P and falls back to 0, so a frame is 2P ticks. An output with compare c (1 ≤ c ≤ P) is high for 2c−1 ticks per frame.
- R5: CTRL bits [6:4] hold a prescaler code n. The counter advances once every 4^n clocks for n ≤ 5. Codes 6 and 7 divide by 1024, the same as code 5.
- R6: A CTRL write while the run bit (CTRL bit 0) is set leaves the mode field (bits [2:1]) and the prescaler field unchanged, and readback shows the old values.
- R7: After a CTRL write that clears the run bit, both outputs are low from the next clock onward and the count holds its value.
- R8: Setting the run bit from the stopped state loads the count one clock after the write: 0 in up and triangle modes, P in down mode. With divide-by-1, the next clock advances it to 1.
- R9: The overflow pulse lasts one clock after a tick at count = P while counting up. The underflow pulse lasts one clock after a tick at count = 0 while counting down. The interrupt is the OR of the pulses enabled by CTRL bit 8 (overflow) and bit 9 (underflow).
- R10: When the enable bit in BUFCFG is set (bit 0 for compare A, bit 1 for compare B), the active compare takes the buffer value only at the start of counting and at the point chosen by BUFCFG bit 4 (1 = crest, count = P; 0 = trough, count = 0). Buffer writes made at other times leave the active compare unchanged.
- R11: Output A follows compare A and output B follows compare B, each on its own value against the shared count.
- R12: The register byte offsets are CTRL 0x00, BUFCFG 0x04, PERIOD 0x08, CMPA 0x0C, CMPB 0x10, BUFA 0x14, BUFB 0x18 and COUNT 0x1C (read only). Writes take effect at the clock edge, and reads return data combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| pwm_a | output | 1 | PWM output driven by compare A |
| pwm_b | output | 1 | PWM output driven by compare B |
| evt_ovf | output | 1 | One-clock overflow pulse |
| evt_unf | output | 1 | One-clock underflow pulse |
| irq | output | 1 | Interrupt from the enabled events |

## Verification
The bench builds the channel with CNT_W = 16, ADDR_W = 5 and MAX_LOG4 = 5. The narrow counter keeps every period short. The full prescaler range stays in place, so divide-by-1024 and the clamped codes 6 and 7 can be covered within a few thousand clocks. Duty and event counts are measured over whole frames of each mode. The crest and trough transfer points are probed by polling the count through the register port, which pins the exact clock at which the active compare changes.

// File: rtl/pwm_tc_pkg.sv
`timescale 1ns/1ps
package pwm_tc_pkg;

  typedef enum logic [1:0] {
    CM_SAW_UP  = 2'd0,
    CM_SAW_DN  = 2'd1,
    CM_TRI     = 2'd2,
    CM_TRI_ALT = 2'd3
  } cnt_mode_e;

  localparam int unsigned OFS_CTRL   = 32'h00;
  localparam int unsigned OFS_BUFCFG = 32'h04;
  localparam int unsigned OFS_PERIOD = 32'h08;
  localparam int unsigned OFS_CMP0   = 32'h0C;
  localparam int unsigned OFS_BUF0   = 32'h14;
  localparam int unsigned OFS_COUNT  = 32'h1C;

  localparam int unsigned NUM_OUT = 2;

  // clamp a prescaler code to the deepest supported divider stage
  function automatic int unsigned psc_stage(input logic [2:0] code,
                                            input int unsigned max_stage);
    int unsigned c;
    c = int'(code);
    return (c > max_stage) ? max_stage : c;
  endfunction

  // true when the count is moving upward in the given mode
  function automatic logic counting_up(input cnt_mode_e m, input logic up);
    return (m == CM_SAW_UP) || ((m == CM_TRI || m == CM_TRI_ALT) && up);
  endfunction

endpackage

// File: rtl/pwm_tc_prescaler.sv
`timescale 1ns/1ps
module pwm_tc_prescaler #(
  parameter int unsigned MAX_LOG4 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  localparam int unsigned PW = (MAX_LOG4 == 0) ? 1 : 2 * MAX_LOG4;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb begin
    lim = PW'((64'd1 << (2 * pwm_tc_pkg::psc_stage(code, MAX_LOG4))) - 64'd1);
  end

  assign tick = en && (pcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (en)      pcnt <= (pcnt == lim) ? '0 : pcnt + 1'b1;
  end

  // R5: the divider never runs past its limit
  p_psc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !restart && (pcnt == lim) |=> (pcnt == '0) || !en);

endmodule

// File: rtl/pwm_tc_counter.sv
`timescale 1ns/1ps
module pwm_tc_counter
  import pwm_tc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             start,
  output logic             crest,
  output logic             trough,
  output logic             ovf,
  output logic             unf
);
  logic             up;
  logic [CNT_W-1:0] nxt;
  logic             nxt_up;
  logic             at_top, at_bot;
  logic             ovf_ev, unf_ev;

  assign start  = run && !active;
  assign at_top = (cnt == period);
  assign at_bot = (cnt == '0);
  assign crest  = tick && at_top;
  assign trough = tick && at_bot;
  assign ovf_ev = crest && counting_up(mode, up);
  assign unf_ev = trough && !counting_up(mode, up);

  always_comb begin
    nxt    = cnt;
    nxt_up = up;
    case (mode)
      CM_SAW_UP: nxt = at_top ? '0 : cnt + 1'b1;
      CM_SAW_DN: nxt = at_bot ? period : cnt - 1'b1;
      default: begin
        if (up) begin
          if (at_top) begin
            nxt_up = 1'b0;
            nxt    = at_bot ? cnt : cnt - 1'b1;
          end else begin
            nxt = cnt + 1'b1;
          end
        end else begin
          if (at_bot) begin
            nxt_up = 1'b1;
            nxt    = at_top ? cnt : cnt + 1'b1;
          end else begin
            nxt = cnt - 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      up     <= 1'b1;
      active <= 1'b0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      active <= run;
      ovf    <= ovf_ev;
      unf    <= unf_ev;
      if (start) begin
        cnt <= (mode == CM_SAW_DN) ? period : '0;
        up  <= (mode != CM_SAW_DN);
      end else if (tick) begin
        cnt <= nxt;
        up  <= nxt_up;
      end
    end
  end

  // R8: a start from idle loads the origin of the count
  p_start_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) && (mode != CM_SAW_DN) |-> (cnt == '0));

  // R7: a stopped channel keeps its count
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !active |=> $stable(cnt));

  // R9: overflow only follows a tick at the period value
  p_ovf_at_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(cnt) == $past(period));

  // R9: overflow and underflow never coincide
  p_evt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

endmodule

// File: rtl/pwm_tc_compare.sv
`timescale 1ns/1ps
module pwm_tc_compare #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp,
  input  logic             wr_buf,
  input  logic [CNT_W-1:0] wdata,
  input  logic             buf_en,
  input  logic             xfer,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] bufv,
  output logic             pwm
);
  logic load_buf;

  assign load_buf = xfer && buf_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      bufv <= '0;
    end else begin
      if (wr_buf)        bufv <= wdata;
      if (load_buf)      cmp  <= bufv;
      else if (wr_cmp)   cmp  <= wdata;
    end
  end

  assign pwm = active && (cnt < cmp);

  // R10: the active compare only moves on a transfer or a direct write
  p_cmp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_buf && !wr_cmp |=> $stable(cmp));

  // R10: a transfer copies the buffer contents
  p_xfer_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_buf |=> cmp == $past(bufv));

endmodule

// File: rtl/pwm_tc_chan.sv
`timescale 1ns/1ps
module pwm_tc_chan
  import pwm_tc_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned MAX_LOG4 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              evt_ovf,
  output logic              evt_unf,
  output logic              irq
);
  // control state
  logic             run_q;
  cnt_mode_e        mode_q;
  logic [2:0]       psc_q;
  logic             ie_ovf_q, ie_unf_q;
  logic [NUM_OUT-1:0] buf_en_q;
  logic             xfer_crest_q;
  logic [CNT_W-1:0] period_q;

  // internal events
  logic             wr_ctrl, wr_bufcfg, wr_period;
  logic             tick, start, crest, trough, active, xfer;
  logic [CNT_W-1:0] cnt;

  logic [NUM_OUT-1:0] wr_cmp_v, wr_buf_v, pwm_v;
  logic [CNT_W-1:0]   cmp_v  [NUM_OUT];
  logic [CNT_W-1:0]   bufv_v [NUM_OUT];

  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_bufcfg = bus_wr && (bus_addr == ADDR_W'(OFS_BUFCFG));
  assign wr_period = bus_wr && (bus_addr == ADDR_W'(OFS_PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      mode_q       <= CM_SAW_UP;
      psc_q        <= '0;
      ie_ovf_q     <= 1'b0;
      ie_unf_q     <= 1'b0;
      buf_en_q     <= '0;
      xfer_crest_q <= 1'b0;
      period_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q    <= bus_wdata[0];
        ie_ovf_q <= bus_wdata[8];
        ie_unf_q <= bus_wdata[9];
        if (!run_q) begin
          mode_q <= cnt_mode_e'(bus_wdata[2:1]);
          psc_q  <= bus_wdata[6:4];
        end
      end
      if (wr_bufcfg) begin
        buf_en_q     <= bus_wdata[NUM_OUT-1:0];
        xfer_crest_q <= bus_wdata[4];
      end
      if (wr_period) period_q <= bus_wdata;
    end
  end

  pwm_tc_prescaler #(.MAX_LOG4(MAX_LOG4)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run_q && active),
    .restart (start),
    .code    (psc_q),
    .tick    (tick)
  );

  pwm_tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .tick   (tick),
    .mode   (mode_q),
    .period (period_q),
    .cnt    (cnt),
    .active (active),
    .start  (start),
    .crest  (crest),
    .trough (trough),
    .ovf    (evt_ovf),
    .unf    (evt_unf)
  );

  assign xfer = start || (xfer_crest_q ? crest : trough);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cmp
    assign wr_cmp_v[i] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP0 + 4 * i));
    assign wr_buf_v[i] = bus_wr && (bus_addr == ADDR_W'(OFS_BUF0 + 4 * i));

    pwm_tc_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_cmp (wr_cmp_v[i]),
      .wr_buf (wr_buf_v[i]),
      .wdata  (bus_wdata),
      .buf_en (buf_en_q[i]),
      .xfer   (xfer),
      .active (active),
      .cnt    (cnt),
      .cmp    (cmp_v[i]),
      .bufv   (bufv_v[i]),
      .pwm    (pwm_v[i])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];
  assign irq   = (evt_ovf && ie_ovf_q) || (evt_unf && ie_unf_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):
        bus_rdata = CNT_W'({ie_unf_q, ie_ovf_q, 1'b0, psc_q, 1'b0, mode_q, run_q});
      ADDR_W'(OFS_BUFCFG):
        bus_rdata = CNT_W'({xfer_crest_q, 2'b00, buf_en_q});
      ADDR_W'(OFS_PERIOD):   bus_rdata = period_q;
      ADDR_W'(OFS_CMP0):     bus_rdata = cmp_v[0];
      ADDR_W'(OFS_CMP0 + 4): bus_rdata = cmp_v[1];
      ADDR_W'(OFS_BUF0):     bus_rdata = bufv_v[0];
      ADDR_W'(OFS_BUF0 + 4): bus_rdata = bufv_v[1];
      ADDR_W'(OFS_COUNT):    bus_rdata = cnt;
      default:               bus_rdata = '0;
    endcase
  end

  // R6: mode and prescaler stay frozen while running
  p_mode_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(mode_q) && $stable(psc_q));

  // R7: an idle counter keeps both outputs low
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pwm_a && !pwm_b);

  // R9: interrupt only with an enabled event
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_ovf || evt_unf);

endmodule

// File: tb/test_pwm_tc_chan.sv
`timescale 1ns/1ps
module test_pwm_tc_chan;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned ADDR_W = 5;

  localparam int A_CTRL = 'h00, A_BCFG = 'h04, A_PER = 'h08, A_CMPA = 'h0C,
                 A_CMPB = 'h10, A_BUFA = 'h14, A_BUFB = 'h18, A_CNT = 'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic pwm_a, pwm_b, evt_ovf, evt_unf, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_tc_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MAX_LOG4(5)) i_pwm_tc_chan (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .evt_ovf(evt_ovf), .evt_unf(evt_unf), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  psc;
    logic [1:0]  ie;
    logic [15:0] per;
    logic [15:0] ca;
    logic [15:0] cb;
    int unsigned frame;
    int unsigned ea;
    int unsigned eb;
    int unsigned eo;
    int unsigned eu;
    int unsigned ei;
  } vec_t;

  // per-frame expectations: frame length, high A, high B, ovf, unf, irq
  localparam vec_t VECS [6] = '{
    '{2'd0, 3'd0, 2'd1, 16'd9, 16'd3, 16'd7,   10,    3,    7, 1, 0, 1},
    '{2'd1, 3'd0, 2'd2, 16'd9, 16'd0, 16'd10,  10,    0,   10, 0, 1, 1},
    '{2'd2, 3'd0, 2'd1, 16'd8, 16'd3, 16'd8,   16,    5,   15, 1, 1, 1},
    '{2'd0, 3'd1, 2'd0, 16'd4, 16'd2, 16'd5,   20,    8,   20, 1, 0, 0},
    '{2'd2, 3'd2, 2'd3, 16'd3, 16'd1, 16'd2,   96,   16,   48, 1, 1, 2},
    '{2'd1, 3'd7, 2'd0, 16'd1, 16'd1, 16'd2, 2048, 1024, 2048, 0, 1, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = ADDR_W'(a);
    bus_wdata = CNT_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = ADDR_W'(a);
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_count(input int target);
    int v;
    for (int k = 0; k < 400; k++) begin
      rd(A_CNT, v);
      if (v == target) break;
      @(negedge clk);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    return (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-R: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 register map reads
    chk("R1 pwm_a", int'(pwm_a), 0);
    chk("R1 pwm_b", int'(pwm_b), 0);
    chk("R1 ovf", int'(evt_ovf), 0);
    chk("R1 unf", int'(evt_unf), 0);
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 32; a += 4) begin
      rd(a, v);
      chk("R1 R12 reg", v, 0);
    end

    // main vector walk: R2 R3 R4 R5 R9 R11
    for (int i = 0; i < 6; i++) begin
      int ha, hb, no, nu, ni;
      vec_t t;
      t = VECS[i];
      wr(A_CTRL, 0);
      wr(A_BCFG, 0);
      wr(A_PER, int'(t.per));
      wr(A_CMPA, int'(t.ca));
      wr(A_CMPB, int'(t.cb));
      wr(A_CTRL, 1 | (int'(t.mode) << 1) | (int'(t.psc) << 4) | (int'(t.ie) << 8));
      repeat (2 * t.frame + 5) @(negedge clk);
      ha = 0; hb = 0; no = 0; nu = 0; ni = 0;
      for (int k = 0; k < int'(2 * t.frame); k++) begin
        ha += int'(pwm_a);
        hb += int'(pwm_b);
        no += int'(evt_ovf);
        nu += int'(evt_unf);
        ni += int'(irq);
        @(negedge clk);
      end
      chk({mode_tag(t.mode), " R5 duty A"}, ha, int'(2 * t.ea));
      chk({mode_tag(t.mode), " R11 duty B"}, hb, int'(2 * t.eb));
      chk("R9 ovf count", no, int'(2 * t.eo));
      chk("R9 unf count", nu, int'(2 * t.eu));
      chk("R9 irq count", ni, int'(2 * t.ei));
    end

    // R6 locked mode and prescaler
    wr(A_CTRL, 0);
    wr(A_PER, 9);
    wr(A_CTRL, 1);
    wr(A_CTRL, 1 | (1 << 1) | (3 << 4));
    rd(A_CTRL, v);
    chk("R6 ctrl readback", v, 1);

    // R7 stop forces outputs low and freezes count
    wr(A_CTRL, 0);
    wr(A_CMPA, 0);
    wr(A_CMPB, 10);
    wr(A_CTRL, 1);
    repeat (5) @(negedge clk);
    chk("R11 pwm_b high", int'(pwm_b), 1);
    wr(A_CTRL, 0);
    @(negedge clk);
    chk("R7 pwm_a low", int'(pwm_a), 0);
    chk("R7 pwm_b low", int'(pwm_b), 0);
    rd(A_CNT, c1);
    repeat (3) @(negedge clk);
    rd(A_CNT, c2);
    chk("R7 count held", c2, c1);

    // R8 restart from zero
    wr(A_CTRL, 1);
    @(negedge clk);
    rd(A_CNT, v);
    chk("R8 count origin", v, 0);
    @(negedge clk);
    rd(A_CNT, v);
    chk("R8 first tick", v, 1);

    // R10 buffered transfer, crest then trough
    wr(A_CTRL, 0);
    wr(A_PER, 40);
    wr(A_CMPA, 2);
    wr(A_BUFA, 6);
    wr(A_BCFG, 'h11);
    wr(A_CTRL, 1 | (2 << 1));
    @(negedge clk);
    rd(A_CMPA, v);
    chk("R10 start transfer", v, 6);
    wr(A_BUFA, 3);
    rd(A_CMPA, v);
    chk("R10 buffer held", v, 6);
    wait_count(40);
    rd(A_CMPA, v);
    chk("R10 before crest", v, 6);
    @(negedge clk);
    rd(A_CMPA, v);
    chk("R10 crest transfer", v, 3);
    wr(A_BCFG, 'h01);
    wr(A_BUFA, 7);
    wait_count(0);
    rd(A_CMPA, v);
    chk("R10 before trough", v, 3);
    @(negedge clk);
    rd(A_CMPA, v);
    chk("R10 trough transfer", v, 7);
    wr(A_BUFA, 9);
    wait_count(40);
    @(negedge clk);
    rd(A_CMPA, v);
    chk("R10 crest ignored", v, 7);
    wait_count(0);
    @(negedge clk);
    rd(A_CMPA, v);
    chk("R10 second trough", v, 9);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule